// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the cycle controller and storage of a single-clock synchronous SRAM whose inputs are all registered on the rising edge. Each edge is classified as a deselect, the start of a burst, a step to the next burst address, or a hold on the current address. The rule depends on two address strobes, one launched by a processor and one by a cache controller, and on three chip selects. The strobes follow different rules. The processor strobe is masked by the primary select and always opens a burst with a read. The controller strobe is never masked and opens a read or a write, depending on the write controls on that edge.

Burst address sequencing happens outside the block. The controller loads `start_addr` when a burst opens, loads `next_addr` on a step edge, and keeps its registered address on a hold edge. Writes can be masked per 9-bit lane (8 data bits and 1 parity bit), or can cover every lane at once through a global write. Read data leaves through one output register, one clock after the address is registered. The drive flag is gated asynchronously by the output enable. In a system, `rd_drive` enables the pad drivers, and `parked` shows the powered-down, deselected state.

Top module: `bsram_ctrl`

## Requirements
- R1: While `cs_n` is high, a low `proc_strb_n` does not start a burst. With `ctl_strb_n` high, that edge is decoded as a step or hold of the open burst, or as nothing when no burst is open.
- R2: `sel_hi` and `sel_lo_n` are only used on edges where a strobe is in effect. On step and hold edges their values change nothing.
- R3: A strobe edge where `cs_n` is high, `sel_hi` is low or `sel_lo_n` is high deselects the device. `parked` goes high after that edge, that edge produces no read data, and write controls on later strobe-free edges do not change the array.
- R4: A strobe edge selected by the processor strobe (`proc_strb_n` low, `cs_n` low) always opens a burst with a read at `start_addr`. This holds even when the controller strobe or the write controls are also active, and the array is not changed on that edge.
- R5: The write for a burst opened by the processor strobe is taken from a following hold edge, and it lands on the same address.
- R6: A burst opened by the controller strobe alone writes on that edge when the write condition is true, and reads otherwise.
- R7: The write condition is true when `glb_wr_n` is low, or when `lane_en_n` is low and at least one bit of `lane_wr_n` is low. A low `glb_wr_n` writes all lanes, whatever the lane controls are.
- R8: Bit i of `lane_wr_n` gates lane i, which is data bits [9i+8:9i], with bit 9i+8 used as parity. With `lane_en_n` and `glb_wr_n` both high, the edge is a read, whatever `lane_wr_n` is.
- R9: With both strobes inactive and a burst open, a low `step_n` moves the access to `next_addr`, and a high `step_n` repeats the access at the current address.
- R10: Read data for an edge's access is shown on `rdata`, with `rd_drive` high, after the following edge. `rd_drive` is additionally gated combinationally by `oe_n`, with no clock involved.
- R11: An edge that performs a write produces no read data, so `rd_drive` stays low in the cycle that follows it.
- R12: Synchronous reset makes `rd_drive` low and `parked` high, and closes any open burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step (low) or hold (high) |
| cs_n | input | 1 | Primary chip select, active low, masks processor strobe |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| glb_wr_n | input | 1 | Global write, active low |
| lane_en_n | input | 1 | Lane-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| start_addr | input | AW | Address loaded when a burst opens |
| next_addr | input | AW | Address from the external burst sequencer |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data, zero when not driving |
| rd_drive | output | 1 | Output drivers on |
| parked | output | 1 | Deselected, powered-down state |

## Verification
The bench aims at the strobe-masking corners. These are a processor strobe that the primary select blocks, which a faulty design would turn into a new burst at the wrong address, and a controller strobe raised while the select is off, which must park rather than read. A processor strobe given together with write controls must read the old word and leave it unchanged. The write must then come from the following hold edge, so a design that obeys the write controls on the strobe edge corrupts the word. Partial lane writes are read back to check that each parity bit follows its own lane. Secondary selects are toggled during step and hold edges, and a design that still samples them there drops out of the burst. Write controls given while parked are checked to leave the array untouched.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_NEXT,
    CYC_HOLD
  } cyc_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE
  } op_e;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             proc_strb_n,
  input  logic             ctl_strb_n,
  input  logic             step_n,
  input  logic             cs_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             glb_wr_n,
  input  logic             lane_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             burst_open,
  output cyc_e             kind,
  output op_e              op,
  output logic [LANES-1:0] mask
);
  logic proc_go, ctl_go, strobe, chosen, wr_cond;

  always_comb begin
    proc_go = !proc_strb_n && !cs_n;
    ctl_go  = !ctl_strb_n;
    strobe  = proc_go || ctl_go;
    chosen  = !cs_n && sel_hi && !sel_lo_n;
    wr_cond = !glb_wr_n || (!lane_en_n && !(&lane_wr_n));

    if (!glb_wr_n)      mask = '1;
    else if (lane_en_n) mask = '0;
    else                mask = ~lane_wr_n;

    if (strobe)          kind = chosen ? CYC_BEGIN : CYC_DESEL;
    else if (burst_open) kind = step_n ? CYC_HOLD : CYC_NEXT;
    else                 kind = CYC_IDLE;

    unique case (kind)
      CYC_BEGIN:          op = proc_go ? OP_READ : (wr_cond ? OP_WRITE : OP_READ);
      CYC_NEXT, CYC_HOLD: op = wr_cond ? OP_WRITE : OP_READ;
      default:            op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] mask,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re) lane_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             proc_strb_n,
  input  logic             ctl_strb_n,
  input  logic             step_n,
  input  logic             cs_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             glb_wr_n,
  input  logic             lane_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    start_addr,
  input  logic [AW-1:0]    next_addr,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rd_drive,
  output logic             parked
);
  cyc_e             kind;
  op_e              op;
  logic [LANES-1:0] mask;

  logic             open_q, parked_q, rd_q, wr_q, vld_q;
  logic [AW-1:0]    addr_q, addr_nx;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    wdat_q, arr_q;

  bsram_decode #(.LANES(LANES)) u_dec (
    .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .cs_n(cs_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .glb_wr_n(glb_wr_n), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
    .burst_open(open_q), .kind(kind), .op(op), .mask(mask)
  );

  always_comb begin
    unique case (kind)
      CYC_BEGIN: addr_nx = start_addr;
      CYC_NEXT:  addr_nx = next_addr;
      default:   addr_nx = addr_q;
    endcase
  end

  // Stage 1: registered access request; stage 2: output register valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      parked_q <= 1'b1;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= rd_q;
      rd_q  <= (op == OP_READ);
      wr_q  <= (op == OP_WRITE);
      if (kind == CYC_BEGIN) begin
        open_q   <= 1'b1;
        parked_q <= 1'b0;
      end else if (kind == CYC_DESEL) begin
        open_q   <= 1'b0;
        parked_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_nx;
    mask_q <= mask;
    wdat_q <= wdata;
  end

  bsram_lanes #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .we(wr_q), .re(rd_q), .addr(addr_q),
    .mask(mask_q), .wdata(wdat_q), .rdata(arr_q)
  );

  assign rd_drive = vld_q && !oe_n;
  assign rdata    = rd_drive ? arr_q : '0;
  assign parked   = parked_q;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             proc_strb_n,
  input logic             ctl_strb_n,
  input logic             cs_n,
  input logic             sel_hi,
  input logic             sel_lo_n,
  input logic             glb_wr_n,
  input logic             lane_en_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             oe_n,
  input logic             rd_drive,
  input logic             parked
);
  logic sel_ok, strobe_any, desel_now, wr_cond, proc_begin, ctl_wr_begin;
  logic d1, d2, p1, p2, w1, w2;
  logic rst_q = 1'b0;

  always_comb begin
    sel_ok       = !cs_n && sel_hi && !sel_lo_n;
    strobe_any   = !ctl_strb_n || (!proc_strb_n && !cs_n);
    desel_now    = strobe_any && !sel_ok;
    wr_cond      = !glb_wr_n || (!lane_en_n && !(&lane_wr_n));
    proc_begin   = !proc_strb_n && sel_ok;
    ctl_wr_begin = !ctl_strb_n && proc_strb_n && sel_ok && wr_cond;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      d1 <= 1'b0; d2 <= 1'b0; p1 <= 1'b0; p2 <= 1'b0; w1 <= 1'b0; w2 <= 1'b0;
    end else begin
      d1 <= desel_now;    d2 <= d1;
      p1 <= proc_begin;   p2 <= p1;
      w1 <= ctl_wr_begin; w2 <= w1;
    end
  end

  always @(posedge clk) begin
    if (rst_q) assert_reset_quiet_R12: assert (!rd_drive && parked);
  end

  assert_blocked_proc_R1: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && cs_n && ctl_strb_n && parked) |=> parked);
  assert_desel_park_R3: assert property (@(posedge clk) disable iff (rst)
    desel_now |=> parked);
  assert_desel_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    d2 |-> !rd_drive);
  assert_proc_opens_R4: assert property (@(posedge clk) disable iff (rst)
    proc_begin |=> !parked);
  assert_proc_reads_R4: assert property (@(posedge clk) disable iff (rst)
    (p2 && !oe_n) |-> rd_drive);
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rd_drive);
  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    w2 |-> !rd_drive);
endmodule

bind bsram_ctrl bsram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n),
  .cs_n(cs_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .glb_wr_n(glb_wr_n),
  .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
  .rd_drive(rd_drive), .parked(parked)
);

// File: tb/sim_bsram_ctrl.sv
module sim_bsram_ctrl;
  localparam int LANES = 4, LANE_W = 9, DEPTH = 16;
  localparam int AW = $clog2(DEPTH), DW = LANES * LANE_W;

  typedef struct packed {
    logic proc_n, ctl_n, step_n, cs_n, sel_hi, sel_lo_n, gw_n, bwe_n;
    logic [3:0]  lanes_n;
    logic [3:0]  addr;
    logic [3:0]  nxt;
    logic        oe_n;
    logic [35:0] wd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1,0,1,0,1,0,0,1,4'hF,4'd3,4'd0,0,36'h1_2345_6789}, // 0  R6 R7 ctl begin, global write
    '{1,1,0,0,1,0,0,1,4'hF,4'd0,4'd4,0,36'h9_8765_4321}, // 1  R9 step, global write
    '{1,0,1,0,1,0,1,1,4'hF,4'd3,4'd0,0,36'h0},           // 2  R6 ctl begin read
    '{1,1,0,0,0,0,1,1,4'hF,4'd0,4'd4,0,36'h0},           // 3  R2 step with sel_hi low
    '{1,1,1,0,1,1,1,1,4'hF,4'd0,4'd9,0,36'h0},           // 4  R2 R9 hold with sel_lo_n high
    '{0,1,1,0,1,0,0,1,4'hF,4'd5,4'd0,0,36'hF_FFFF_FFFF}, // 5  R4 proc begin with write controls
    '{1,1,1,0,1,0,1,0,4'b1010,4'd0,4'd0,0,36'hA_BCDE_F012}, // 6 R5 R8 R11 lane write on hold
    '{1,0,1,0,1,0,1,1,4'h0,4'd5,4'd0,0,36'hF_FFFF_FFFF}, // 7  R8 lanes low, enable high: read
    '{1,0,1,0,0,0,1,1,4'hF,4'd0,4'd0,0,36'h0},           // 8  R3 deselect via sel_hi
    '{1,1,0,0,1,0,0,1,4'hF,4'd0,4'd7,0,36'h5_5555_5555}, // 9  R3 parked: write ignored
    '{0,1,1,1,1,0,1,1,4'hF,4'd2,4'd0,0,36'h0},           // 10 R1 blocked proc strobe while parked
    '{1,0,1,0,1,0,1,1,4'hF,4'd7,4'd0,0,36'h0},           // 11 R3 read addr 7 unchanged
    '{0,1,1,1,1,0,1,1,4'hF,4'd1,4'd0,0,36'h0},           // 12 R1 blocked proc strobe = hold
    '{1,0,1,1,1,0,1,1,4'hF,4'd0,4'd0,0,36'h0},           // 13 R3 ctl strobe with cs_n high
    '{0,0,1,0,1,0,1,0,4'h0,4'd9,4'd0,0,36'h3_3333_3333}, // 14 R4 both strobes, lanes active
    '{1,1,0,0,1,0,1,1,4'hF,4'd0,4'd10,1,36'h0},          // 15 R9 R10 step, oe off
    '{1,1,1,0,1,0,1,1,4'hF,4'd0,4'd0,1,36'h0},           // 16 R10 hold, oe off
    '{1,0,1,0,1,0,1,1,4'hF,4'd9,4'd0,0,36'h0},           // 17 R4 addr 9 unchanged
    '{1,1,1,0,1,0,1,0,4'b0111,4'd0,4'd0,0,36'hC_0000_0000}, // 18 R8 top lane with parity bit
    '{1,0,1,0,1,0,1,1,4'hF,4'd9,4'd0,0,36'h0},           // 19 R8 read back
    '{1,1,1,0,1,0,0,1,4'h0,4'd0,4'd0,0,36'h0_0000_0000}, // 20 R7 global write beats lanes
    '{1,0,1,0,1,0,1,1,4'hF,4'd9,4'd0,0,36'h0}            // 21 R7 read back
  };

  logic clk = 1'b0, rst = 1'b1;
  logic proc_strb_n = 1, ctl_strb_n = 1, step_n = 1, cs_n = 0, sel_hi = 1, sel_lo_n = 0;
  logic glb_wr_n = 1, lane_en_n = 1, oe_n = 0;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [AW-1:0] start_addr = '0, next_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_drive, parked;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] ref_m [DEPTH];
  logic          m_open, m_parked, v1, v2;
  logic [DW-1:0] d1, d2;
  logic [AW-1:0] m_addr;

  always #5 clk = ~clk;

  bsram_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n),
    .step_n(step_n), .cs_n(cs_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .glb_wr_n(glb_wr_n), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
    .start_addr(start_addr), .next_addr(next_addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rd_drive(rd_drive), .parked(parked)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of one rising edge, built from the requirements.
  task automatic model_edge();
    bit pgo, strobe, wc, acc, wr;
    if (rst) begin
      m_open = 0; m_parked = 1; v1 = 0; v2 = 0;
      return;
    end
    v2 = v1; d2 = d1; v1 = 0; acc = 0;
    pgo    = !proc_strb_n && !cs_n;
    strobe = pgo || !ctl_strb_n;
    wc     = !glb_wr_n || (!lane_en_n && lane_wr_n != '1);
    wr     = 0;
    if (strobe) begin
      if (cs_n || !sel_hi || sel_lo_n) begin
        m_open = 0; m_parked = 1;
      end else begin
        m_open = 1; m_parked = 0; m_addr = start_addr; acc = 1;
        wr = !pgo && wc;
      end
    end else if (m_open) begin
      if (!step_n) m_addr = next_addr;
      acc = 1; wr = wc;
    end
    if (acc && wr) begin
      for (int i = 0; i < LANES; i++)
        if (!glb_wr_n || !lane_wr_n[i])
          ref_m[m_addr][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
    end else if (acc) begin
      v1 = 1; d1 = ref_m[m_addr];
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    proc_strb_n = v.proc_n; ctl_strb_n = v.ctl_n; step_n = v.step_n; cs_n = v.cs_n;
    sel_hi = v.sel_hi; sel_lo_n = v.sel_lo_n; glb_wr_n = v.gw_n; lane_en_n = v.bwe_n;
    lane_wr_n = v.lanes_n; start_addr = v.addr; next_addr = v.nxt; oe_n = v.oe_n; wdata = v.wd;
    @(posedge clk);
    model_edge();
    #2;
    check(rd_drive === (v2 && !oe_n), "R10 drive", {35'd0, rd_drive}, {35'd0, v2 && !oe_n});
    if (v2 && !oe_n) check(rdata === d2, "R10 data", rdata, d2);
    check(parked === m_parked, "R3 parked", {35'd0, parked}, {35'd0, m_parked});
  endtask

  function automatic vec_t idle_vec();
    return '{1,1,1,0,1,0,1,1,4'hF,4'd0,4'd0,0,36'h0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    m_open = 0; m_parked = 1; v1 = 0; v2 = 0; d1 = '0; d2 = '0; m_addr = '0;
    for (int i = 0; i < DEPTH; i++) ref_m[i] = '0;
    repeat (3) begin @(posedge clk); model_edge(); end
    #2;
    check(rd_drive === 1'b0 && parked === 1'b1, "R12 reset state", {34'd0, rd_drive, parked}, 36'd1);
    @(negedge clk); rst = 0;

    // Fill the array: ctl begin with global write, then steps (R6 R7 R9).
    for (int i = 0; i < DEPTH; i++) begin
      v = '{1,1,0,0,1,0,0,1,4'hF,4'd0,4'd0,0,36'h0};
      if (i == 0) begin v.ctl_n = 0; v.step_n = 1; end
      v.nxt = 4'(i);
      v.wd  = {9{4'(i)}};
      apply(v);
    end

    for (int k = 0; k < NV; k++) apply(TBL[k]);
    apply(idle_vec());
    apply(idle_vec());

    // R10: oe_n gates the drive flag without a clock edge.
    v = TBL[2]; v.addr = 4'd2; apply(v);
    apply(idle_vec());
    oe_n = 1; #1;
    check(rd_drive === 1'b0, "R10 oe async off", {35'd0, rd_drive}, 36'd0);
    oe_n = 0; #1;
    check(rd_drive === 1'b1 && rdata === ref_m[2], "R10 oe async on", rdata, ref_m[2]);

    // R12: mid-run reset with valid read data in the pipeline.
    @(negedge clk); rst = 1;
    @(posedge clk); model_edge(); #2;
    check(rd_drive === 1'b0 && parked === 1'b1, "R12 reset mid-run", {34'd0, rd_drive, parked}, 36'd1);
    @(negedge clk); rst = 0;
    // After reset no burst is open: a hold edge must not read (R12).
    apply(idle_vec());
    apply(idle_vec());

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule